// File: doc/BRIEF.md
# Ethernet PHY Basic Control Register

This block holds the basic control word of an Ethernet PHY as it appears on a management register port. A management agent writes and reads a 16-bit word. Four bits of that word act on the PHY. The first enables auto-negotiation, and an external strap pin can veto it. The second isolates the PHY from its MII data paths. The third is a self-clearing strobe that restarts negotiation. The fourth forces full duplex while negotiation is off. There is no power-down function. Every other bit reads as zero.

The block drives four signals toward the rest of the PHY: the effective negotiation enable, a single-cycle restart pulse for the negotiation engine, the effective duplex and the isolate state. It also sits in the MII data paths. While isolated, it drops the transmit data arriving from the MAC and turns off the output enable of the receive data pins. Serial management framing and the negotiation state machine are handled elsewhere.

The reset input asserts asynchronously. Its release is synchronised to the clock through a short flop chain.

Top module: `phy_ctl_reg`

## Requirements
- R1: While reset is applied, the read word is 0x1000 (enable bit 12 set, all others 0), isolate and full duplex are 0 and no restart pulse is driven.
- R2: With the strap pin high, a write stores bit 12, and later reads return the value written.
- R3: With the strap pin low, writes to bit 12 are ignored and the read value of bit 12 does not change.
- R4: The effective negotiation enable equals the strap pin AND the stored bit 12.
- R5: Bit 10 is the isolate control. A write stores it, reads return it, and the isolate output follows it.
- R6: While isolated, the transmit valid and transmit data toward the core are 0 and the receive output enable is 0. Otherwise transmit and receive data, valid and enable pass straight through.
- R7: A write with bit 9 set drives a restart pulse for exactly the one cycle after the write edge. This happens only if the enable that results from that write is high. Bit 9 always reads 0.
- R8: A write with bit 9 clear produces no restart pulse. A write with bit 9 set also produces none when the resulting enable is low.
- R9: A write stores bit 8 only when the effective enable was low before the write. Bit 8 reads back as stored. The full-duplex output is bit 8 AND NOT the effective enable.
- R10: Bits 15..13, 11 and 7..0 read as 0 and ignore writes.
- R11: Asserting reset clears the register state at once. After reset is released, writes take effect only from the third rising edge on (two synchroniser stages).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register read data |
| an_pin | input | 1 | Hardware negotiation enable strap, low disables |
| an_active | output | 1 | Effective negotiation enable |
| an_restart | output | 1 | One-cycle restart pulse to the negotiation engine |
| full_duplex | output | 1 | Effective duplex, 1 = full |
| isolate | output | 1 | Isolate state |
| mac_txd | input | 4 | Transmit data from the MAC |
| mac_tx_en | input | 1 | Transmit valid from the MAC |
| core_txd | output | 4 | Gated transmit data toward the PHY core |
| core_tx_en | output | 1 | Gated transmit valid toward the PHY core |
| core_rxd | input | 4 | Receive data from the PHY core |
| core_rx_dv | input | 1 | Receive valid from the PHY core |
| mii_rxd | output | 4 | Receive data toward the MAC |
| mii_rx_dv | output | 1 | Receive valid toward the MAC |
| mii_rx_oe | output | 1 | Output enable for the receive pins, 0 = high impedance |

## Verification
The bench uses the defaults: a 4-bit MII data width and two reset synchroniser stages. With the narrow data width, every gated data line can be checked against a single alternating pattern. With the short synchroniser, the window in which writes are ignored after reset release is only two edges long, so the bench can check each edge of it. The vector walk covers the ordering corners: a write that disables negotiation and sets bit 8 in the same word, restart requests under a low pin or a cleared enable bit, and strap changes between writes.

// File: rtl/phy_ctl_pkg.sv
package phy_ctl_pkg;
  localparam int REG_W      = 16;
  // Bit positions decoded by the management agent
  localparam int POS_AN_EN  = 12;
  localparam int POS_ISO    = 10;
  localparam int POS_RESTRT = 9;
  localparam int POS_DUPLEX = 8;

  typedef struct packed {
    logic an_en;
    logic iso;
    logic restart;
    logic duplex;
  } ctl_wr_t;
endpackage

// File: rtl/phy_rst_sync.sv
module phy_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/phy_ctl_regs.sv
module phy_ctl_regs
  import phy_ctl_pkg::*;
(
  input  logic    clk,
  input  logic    rst_ni,
  input  logic    wr_en,
  input  ctl_wr_t wr_bits,
  input  logic    an_pin,
  output logic    an_sw,
  output logic    iso,
  output logic    dup_bit,
  output logic    an_active,
  output logic    restart_pulse
);
  logic an_sw_q, an_sw_d, an_sw_ce;
  logic iso_q, iso_d, iso_ce;
  logic dup_q, dup_d, dup_ce;
  logic rst_q, rst_d;
  logic en_after_wr;

  assign an_active = an_pin & an_sw_q;

  always_comb begin
    an_sw_ce    = wr_en & an_pin;
    an_sw_d     = wr_bits.an_en;
    iso_ce      = wr_en;
    iso_d       = wr_bits.iso;
    dup_ce      = wr_en & ~an_active;
    dup_d       = wr_bits.duplex;
    en_after_wr = an_pin & (an_sw_ce ? an_sw_d : an_sw_q);
    rst_d       = wr_en & wr_bits.restart & en_after_wr;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      an_sw_q <= 1'b1;
      iso_q   <= 1'b0;
      dup_q   <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      if (an_sw_ce) an_sw_q <= an_sw_d;
      if (iso_ce)   iso_q   <= iso_d;
      if (dup_ce)   dup_q   <= dup_d;
      rst_q <= rst_d;
    end
  end

  assign an_sw         = an_sw_q;
  assign iso           = iso_q;
  assign dup_bit       = dup_q;
  assign restart_pulse = rst_q;

  // R7
  restart_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    restart_pulse |=> !restart_pulse);
  // R8
  restart_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    restart_pulse |-> $past(wr_en && wr_bits.restart && an_pin));
  // R3
  pin_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ($past(!an_pin) && $past(wr_en)) |-> $stable(an_sw));
  // R9
  duplex_locked_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ($past(an_active) && $past(wr_en)) |-> $stable(dup_bit));
  // R5
  iso_clear_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $past(wr_en && !wr_bits.iso) |-> !iso);
endmodule

// File: rtl/phy_mii_gate.sv
module phy_mii_gate #(
  parameter int DATA_W = 4
) (
  input  logic              iso,
  input  logic [DATA_W-1:0] mac_txd,
  input  logic              mac_tx_en,
  output logic [DATA_W-1:0] core_txd,
  output logic              core_tx_en,
  input  logic [DATA_W-1:0] core_rxd,
  input  logic              core_rx_dv,
  output logic [DATA_W-1:0] mii_rxd,
  output logic              mii_rx_dv,
  output logic              mii_rx_oe
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    assign core_txd[i] = mac_txd[i] & ~iso;
    assign mii_rxd[i]  = core_rxd[i] & ~iso;
  end

  assign core_tx_en = mac_tx_en & ~iso;
  assign mii_rx_dv  = core_rx_dv & ~iso;
  assign mii_rx_oe  = ~iso;

  // R6
  iso_gate_chk: assert final (!(iso && (core_tx_en || mii_rx_oe || mii_rx_dv)));
endmodule

// File: rtl/phy_ctl_reg.sv
module phy_ctl_reg
  import phy_ctl_pkg::*;
#(
  parameter int DATA_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  input  logic              an_pin,
  output logic              an_active,
  output logic              an_restart,
  output logic              full_duplex,
  output logic              isolate,
  input  logic [DATA_W-1:0] mac_txd,
  input  logic              mac_tx_en,
  output logic [DATA_W-1:0] core_txd,
  output logic              core_tx_en,
  input  logic [DATA_W-1:0] core_rxd,
  input  logic              core_rx_dv,
  output logic [DATA_W-1:0] mii_rxd,
  output logic              mii_rx_dv,
  output logic              mii_rx_oe
);
  logic    rst_ni;
  ctl_wr_t wr_bits;
  logic    an_sw, iso, dup_bit;
  logic    wr_spare_bits;

  assign wr_bits.an_en   = wr_data[POS_AN_EN];
  assign wr_bits.iso     = wr_data[POS_ISO];
  assign wr_bits.restart = wr_data[POS_RESTRT];
  assign wr_bits.duplex  = wr_data[POS_DUPLEX];
  assign wr_spare_bits   = ^{wr_data[15:13], wr_data[11], wr_data[7:0]};

  phy_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_ni));

  phy_ctl_regs u_regs (
    .clk(clk), .rst_ni(rst_ni), .wr_en(wr_en), .wr_bits(wr_bits),
    .an_pin(an_pin), .an_sw(an_sw), .iso(iso), .dup_bit(dup_bit),
    .an_active(an_active), .restart_pulse(an_restart));

  phy_mii_gate #(.DATA_W(DATA_W)) u_gate (
    .iso(iso), .mac_txd(mac_txd), .mac_tx_en(mac_tx_en),
    .core_txd(core_txd), .core_tx_en(core_tx_en),
    .core_rxd(core_rxd), .core_rx_dv(core_rx_dv),
    .mii_rxd(mii_rxd), .mii_rx_dv(mii_rx_dv), .mii_rx_oe(mii_rx_oe));

  always_comb begin
    rd_data             = '0;
    rd_data[POS_AN_EN]  = an_sw;
    rd_data[POS_ISO]    = iso;
    rd_data[POS_DUPLEX] = dup_bit;
  end

  assign full_duplex = dup_bit & ~an_active;
  assign isolate     = iso;

  // R9
  duplex_vs_neg_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    full_duplex |-> !an_active);
  // R10
  spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_data & 16'hEAFF) == 16'h0 || wr_spare_bits);
endmodule

// File: tb/sim_phy_ctl_reg.sv
module sim_phy_ctl_reg;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic        an_pin, an_active, an_restart, full_duplex, isolate;
  logic [3:0]  mac_txd, core_txd, core_rxd, mii_rxd;
  logic        mac_tx_en, core_tx_en, core_rx_dv, mii_rx_dv, mii_rx_oe;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  phy_ctl_reg u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .an_pin(an_pin), .an_active(an_active),
    .an_restart(an_restart), .full_duplex(full_duplex), .isolate(isolate),
    .mac_txd(mac_txd), .mac_tx_en(mac_tx_en), .core_txd(core_txd),
    .core_tx_en(core_tx_en), .core_rxd(core_rxd), .core_rx_dv(core_rx_dv),
    .mii_rxd(mii_rxd), .mii_rx_dv(mii_rx_dv), .mii_rx_oe(mii_rx_oe));

  // {pin, we, wdata, exp_rd, act, restart, fdx, iso}
  localparam int NV = 15;
  localparam logic [37:0] VEC [NV] = '{
    {1'b1, 1'b0, 16'h0000, 16'h1000, 4'b1000}, // R2 idle
    {1'b1, 1'b1, 16'h1100, 16'h1000, 4'b1000}, // R9 dup locked
    {1'b1, 1'b1, 16'h1200, 16'h1000, 4'b1100}, // R7 restart
    {1'b1, 1'b0, 16'h0000, 16'h1000, 4'b1000}, // R7 pulse gone
    {1'b1, 1'b1, 16'h0100, 16'h0000, 4'b0000}, // R2 R9 disable, dup ignored
    {1'b1, 1'b1, 16'h0100, 16'h0100, 4'b0010}, // R9 dup forced
    {1'b1, 1'b1, 16'h0300, 16'h0100, 4'b0010}, // R8 restart ignored
    {1'b1, 1'b1, 16'hEDFF, 16'h0500, 4'b0011}, // R10 R5 spare bits
    {1'b0, 1'b1, 16'h1500, 16'h0500, 4'b0011}, // R3 pin low
    {1'b0, 1'b1, 16'h1700, 16'h0500, 4'b0011}, // R8 pin low
    {1'b1, 1'b0, 16'h0000, 16'h0500, 4'b0011}, // R4 sw bit low
    {1'b1, 1'b1, 16'h1300, 16'h1100, 4'b1100}, // R7 enable and restart
    {1'b0, 1'b0, 16'h0000, 16'h1100, 4'b0010}, // R4 pin drops
    {1'b0, 1'b1, 16'h0000, 16'h1000, 4'b0000}, // R3 R9
    {1'b1, 1'b0, 16'h0000, 16'h1000, 4'b1000}  // R4
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; an_pin = 1'b1;
    mac_txd = 4'hA; mac_tx_en = 1'b1; core_rxd = 4'h5; core_rx_dv = 1'b1;
    tick(); tick();
    // R1 reset state
    check("R1", {an_restart, full_duplex, isolate, rd_data}, {3'b000, 16'h1000});
    rst_n = 1'b1;
    tick(); tick(); tick();

    for (int i = 0; i < NV; i++) begin
      an_pin  = VEC[i][37];
      wr_en   = VEC[i][36];
      wr_data = VEC[i][35:20];
      tick();
      wr_en = 1'b0;
      check("R2-table", {an_active, an_restart, full_duplex, isolate, rd_data},
            {VEC[i][3:0], VEC[i][19:4]});
    end

    // R6 pass-through when not isolated
    check("R6", {core_tx_en, core_txd, mii_rx_dv, mii_rxd, mii_rx_oe},
          {1'b1, 4'hA, 1'b1, 4'h5, 1'b1});
    // R5 isolate on
    wr_en = 1'b1; wr_data = 16'h1400; tick(); wr_en = 1'b0;
    check("R5", {isolate, rd_data}, {1'b1, 16'h1400});
    // R6 gating while isolated
    check("R6", {core_tx_en, core_txd, mii_rx_dv, mii_rxd, mii_rx_oe},
          {1'b0, 4'h0, 1'b0, 4'h0, 1'b0});

    // R11 asynchronous assert, mid-cycle
    #1 rst_n = 1'b0;
    #0.5;
    check("R11", {isolate, rd_data}, {1'b0, 16'h1000});
    tick();
    wr_en = 1'b1; wr_data = 16'h0400;
    rst_n = 1'b1;
    tick();
    check("R11", {31'd0, isolate}, 32'd0);
    tick();
    check("R11", {31'd0, isolate}, 32'd0);
    tick();
    check("R11", {isolate, rd_data}, {1'b1, 16'h0400});
    wr_en = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule